// File: doc/BRIEF.md
# Two-Wire Serial Register Slave

This block is a two-wire serial slave that lets a host set up a small bank of 8-bit control registers for clock-generation logic and read them back. The serial clock and data lines are brought into a fast system clock domain, where start and stop conditions and clock edges are recognised. A byte engine then shifts bits, drives acknowledges through an open-drain enable, and moves through the register bank in order.

The protocol has no register pointer. A write transfer carries the write address, then two filler bytes (a command byte and a count byte) whose values do not matter, and then data bytes that fill register 0, register 1 and so on until a stop. A read transfer returns register 0 first and continues through the bank for as long as the host acknowledges. Some bit fields are fixed or reflect strap inputs and cannot be written. The complete register contents are offered in parallel to the clock logic.

Top module: `sreg_slave`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. SDA is sampled on the rising SCL edge. The slave only begins driving SDA low while SCL is low, and it releases SDA after every stop.
- R2: Address byte 0xD2 (write) and address byte 0xD3 (read) are acknowledged by driving SDA low in the ninth bit. Any other address byte gets no acknowledge, and the rest of that transfer is ignored, so the registers do not change.
- R3: On a write, the two bytes after the address are acknowledged and discarded. Each following byte, sent MSB first, is acknowledged and loads the next register, starting at register 0.
- R4: On a read, bytes are sent MSB first, starting at register 0 and advancing by one after each acknowledge from the host. A not-acknowledge from the host makes the slave release SDA, so further clocked bits read as 1, until the next start or stop.
- R5: After reset the registers read reg0=0x00, reg1=0x0B, reg2=0xFF, reg3=0x37, reg4=0x00 (with strap_i=0), reg5=0x03 and reg6=0x57.
- R6: The writable bits are reg0 bits 6:2, reg1 bits 3,1,0, all of reg2, reg3 bits 6:4 and 2:0, reg4 bits 1:0 and reg5 bits 1:0. No bit of reg6 is writable. Every other bit keeps its reset value when written, except reg4 bits 7:4, which always show strap_i[3:0].
- R7: Data bytes written after register 6 are acknowledged and discarded. Reads after register 6 return 0xFF.
- R8: A start in the middle of a transfer ends that transfer. The next byte is treated as an address, and the next data byte written or read again refers to register 0.
- R9: regs_o carries register i on bits 8*i+7 down to 8*i, for i = 0 to 6. These are the same values a read returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| strap_i | input | 4 | Latched strap levels shown in reg4 bits 7:4 |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| regs_o | output | 56 | Parallel image of registers 0 to 6 |

## Verification
Writes of 0xFF and then 0x00 across nine data bytes separate writable bits from fixed ones, and show that bytes beyond the end are acknowledged and dropped. Foreign address bytes followed by clocked data show that nothing is acknowledged or stored. A repeated start in the middle of a write, and another in the middle of a read, show that the sequence returns to register 0. A not-acknowledge followed by extra clocking shows the line is released, and random write lengths mixed with random read lengths and strap changes compare every byte with a mask-based model.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  localparam int unsigned REG_COUNT = 7;
  localparam int unsigned STRAP_REG = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_SKIP
  } link_st_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_CNT,
    PH_DATA
  } byte_ph_t;

  function automatic logic [7:0] reg_default(int unsigned idx);
    case (idx)
      0: return 8'h00;
      1: return 8'h0B;
      2: return 8'hFF;
      3: return 8'h37;
      4: return 8'h00;
      5: return 8'h03;
      6: return 8'h57;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] reg_wmask(int unsigned idx);
    case (idx)
      0: return 8'h7C;
      1: return 8'h0B;
      2: return 8'hFF;
      3: return 8'h77;
      4: return 8'h03;
      5: return 8'h03;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] apply_write(int unsigned idx, logic [7:0] d);
    return (d & reg_wmask(idx)) | (reg_default(idx) & ~reg_wmask(idx));
  endfunction

  function automatic logic addr_hits(logic [7:0] b, logic [6:0] a7);
    return b[7:1] == a7;
  endfunction

  function automatic int unsigned sat_inc(int unsigned p, int unsigned lim);
    return (p >= lim) ? lim : p + 1;
  endfunction

endpackage

// File: rtl/sreg_line_sync.sv
module sreg_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_q;
  logic              sda_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_s    = scl_ff[STAGES-1];
  assign sda_s    = sda_ff[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_ev && stop_ev) && !(scl_rise && scl_fall)); // R1

endmodule

// File: rtl/sreg_proto.sv
module sreg_proto
  import sreg_pkg::*;
#(
  parameter int unsigned NREG  = REG_COUNT,
  parameter logic [6:0]  ADDR7 = 7'h69,
  localparam int unsigned PTR_W = $clog2(NREG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_ev,
  input  logic             stop_ev,
  input  logic [7:0]       rd_data,
  output logic [PTR_W-1:0] rd_idx,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             sda_oe
);

  link_st_t         st;
  byte_ph_t         ph;
  logic [3:0]       bit_cnt;
  logic [7:0]       rx_sh;
  logic [7:0]       tx_sh;
  logic [PTR_W-1:0] ptr;
  logic             rw;
  logic             m_ack;
  logic             byte_done;
  logic [PTR_W-1:0] ptr_next;

  assign byte_done = scl_fall && (bit_cnt == 4'd8);
  assign ptr_next  = PTR_W'(sat_inc(int'(ptr), NREG));
  assign rd_idx    = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ph      <= PH_ADDR;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '1;
      ptr     <= '0;
      rw      <= 1'b0;
      m_ack   <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
      sda_oe  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_ev) begin
        st      <= ST_RX;
        ph      <= PH_ADDR;
        bit_cnt <= '0;
        ptr     <= '0;
        rw      <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (stop_ev) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (byte_done) begin
              bit_cnt <= '0;
              case (ph)
                PH_ADDR: begin
                  if (addr_hits(rx_sh, ADDR7)) begin
                    sda_oe <= 1'b1;
                    st     <= ST_ACK;
                    rw     <= rx_sh[0];
                    ph     <= PH_CMD;
                  end else begin
                    st <= ST_SKIP;
                  end
                end
                PH_CMD: begin
                  sda_oe <= 1'b1;
                  st     <= ST_ACK;
                  ph     <= PH_CNT;
                end
                PH_CNT: begin
                  sda_oe <= 1'b1;
                  st     <= ST_ACK;
                  ph     <= PH_DATA;
                  ptr    <= '0;
                end
                default: begin
                  sda_oe  <= 1'b1;
                  st      <= ST_ACK;
                  wr_en   <= 1'b1;
                  wr_idx  <= ptr;
                  wr_data <= rx_sh;
                  ptr     <= ptr_next;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (rw) begin
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[7];
                st     <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (byte_done) begin
              bit_cnt <= '0;
              sda_oe  <= 1'b0;
              st      <= ST_MACK;
            end else if (scl_fall) begin
              tx_sh  <= {tx_sh[6:0], 1'b1};
              sda_oe <= ~tx_sh[6];
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_s;
              if (!sda_s) ptr <= ptr_next;
            end else if (scl_fall) begin
              if (m_ack) begin
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[7];
                st     <= ST_TX;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_DRIVE_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R1
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (!sda_oe && st == ST_IDLE)); // R1
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SKIP) |-> !sda_oe); // R2
  AST_WRITE_AFTER_FILLERS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (ph == PH_DATA && !rw)); // R3
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) <= int'(NREG)); // R7
  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (bit_cnt == 4'd0 && ptr == '0 && ph == PH_ADDR && st == ST_RX)); // R8

endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
  import sreg_pkg::*;
#(
  parameter int unsigned NREG    = REG_COUNT,
  parameter int unsigned STRAP_W = 4,
  localparam int unsigned PTR_W  = $clog2(NREG + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [PTR_W-1:0]   wr_idx,
  input  logic [7:0]         wr_data,
  input  logic [PTR_W-1:0]   rd_idx,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [7:0]         rd_data,
  output logic [8*NREG-1:0]  regs_o
);

  logic [7:0]        q    [NREG];
  logic [7:0]        view [NREG];
  logic [8*NREG-1:0] q_flat;

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q[i] <= reg_default(i);
        end else if (wr_en && wr_idx == PTR_W'(i)) begin
          q[i] <= apply_write(i, wr_data);
        end
      end

      if (i == STRAP_REG) begin : g_strap
        assign view[i] = {strap_i, q[i][7-STRAP_W:0]};
      end else begin : g_plain
        assign view[i] = q[i];
      end

      assign regs_o[8*i +: 8] = view[i];
      assign q_flat[8*i +: 8] = q[i];
    end
  endgenerate

  always_comb begin
    rd_data = 8'hFF;
    for (int i = 0; i < NREG; i++) begin
      if (rd_idx == PTR_W'(i)) rd_data = view[i];
    end
  end

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q_flat)); // R6
  AST_PAST_END_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_idx) >= int'(NREG)) |-> (rd_data == 8'hFF)); // R7

endmodule

// File: rtl/sreg_slave.sv
module sreg_slave
  import sreg_pkg::*;
#(
  parameter int unsigned NREG        = REG_COUNT,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STRAP_W     = 4,
  parameter logic [6:0]  ADDR7       = 7'h69,
  localparam int unsigned PTR_W      = $clog2(NREG + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_oe_o,
  output logic [8*NREG-1:0]  regs_o
);

  logic             scl_s;
  logic             sda_s;
  logic             scl_rise;
  logic             scl_fall;
  logic             start_ev;
  logic             stop_ev;
  logic [7:0]       rd_data;
  logic [PTR_W-1:0] rd_idx;
  logic             wr_en;
  logic [PTR_W-1:0] wr_idx;
  logic [7:0]       wr_data;

  sreg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  sreg_proto #(.NREG(NREG), .ADDR7(ADDR7)) u_proto (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .rd_data  (rd_data),
    .rd_idx   (rd_idx),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .sda_oe   (sda_oe_o)
  );

  sreg_bank #(.NREG(NREG), .STRAP_W(STRAP_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .strap_i (strap_i),
    .rd_data (rd_data),
    .regs_o  (regs_o)
  );

endmodule

// File: tb/sreg_slave_test.sv
module sreg_slave_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic [3:0]  strap = 4'h0;
  logic        sda_oe;
  logic [55:0] regs;
  logic        sda_w;

  assign sda_w = sda_m & ~sda_oe;

  sreg_slave uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_w),
    .strap_i  (strap),
    .sda_oe_o (sda_oe),
    .regs_o   (regs)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int oe_glitch = 0;
  bit done   = 1'b0;
  logic [7:0] model [7];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000 && !done) begin
      fails = fails + 1;
      $display("FAIL watchdog expired act=%0d exp=<190000 cycles", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  logic prev_scl = 1'b1, prev_oe = 1'b0;
  always @(negedge clk) begin
    if (scl_m && prev_scl && sda_oe !== prev_oe) oe_glitch++;
    prev_scl <= scl_m;
    prev_oe  <= sda_oe;
  end

  function automatic logic [7:0] m_mask(int i);
    case (i)
      0: return 8'b0111_1100;
      1: return 8'b0000_1011;
      2: return 8'b1111_1111;
      3: return 8'b0111_0111;
      4: return 8'b0000_0011;
      5: return 8'b0000_0011;
      default: return 8'b0000_0000;
    endcase
  endfunction

  function automatic logic [7:0] m_init(int i);
    case (i)
      0: return 8'h00; 1: return 8'h0B; 2: return 8'hFF; 3: return 8'h37;
      4: return 8'h00; 5: return 8'h03; 6: return 8'h57;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] m_view(int i);
    if (i > 6) return 8'hFF;
    if (i == 4) return {strap, model[4][3:0]};
    return model[i];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(bit b);
    tick(3); sda_m = b; tick(3); scl_m = 1'b1; tick(6); scl_m = 1'b0;
  endtask

  task automatic get_bit(output bit b);
    tick(3); sda_m = 1'b1; tick(3); scl_m = 1'b1; tick(3); b = sda_w; tick(3); scl_m = 1'b0;
  endtask

  task automatic do_start();
    tick(3); sda_m = 1'b1; tick(3); scl_m = 1'b1; tick(6); sda_m = 1'b0; tick(6); scl_m = 1'b0;
  endtask

  task automatic do_stop();
    tick(3); sda_m = 1'b0; tick(3); scl_m = 1'b1; tick(6); sda_m = 1'b1; tick(6);
  endtask

  task automatic send_byte(logic [7:0] b, output bit acked);
    bit a;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    get_bit(a);
    acked = !a;
  endtask

  task automatic get_byte(bit give_ack, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    send_bit(!give_ack);
  endtask

  task automatic model_write(int idx, logic [7:0] d);
    if (idx < 7) model[idx] = (d & m_mask(idx)) | (m_init(idx) & ~m_mask(idx));
  endtask

  task automatic write_seq(int n, logic [7:0] fill, bit use_fill);
    bit a;
    logic [7:0] d;
    do_start();
    send_byte(8'hD2, a); chk("R2 write address ack", a, 1);
    send_byte(8'($urandom), a); chk("R3 command byte ack", a, 1);
    send_byte(8'($urandom), a); chk("R3 count byte ack", a, 1);
    for (int k = 0; k < n; k++) begin
      d = use_fill ? fill : 8'($urandom);
      send_byte(d, a);
      if (k >= 7) chk("R7 data past end ack", a, 1);
      else        chk("R3 data byte ack", a, 1);
      model_write(k, d);
    end
    do_stop();
  endtask

  task automatic read_seq(int n);
    bit a;
    logic [7:0] v;
    do_start();
    send_byte(8'hD3, a); chk("R2 read address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      get_byte(k < n - 1, v);
      if (k >= 7) chk("R7 read past end", v, 8'hFF);
      else        chk($sformatf("R4 read reg%0d", k), v, m_view(k));
    end
    do_stop();
  endtask

  task automatic check_image(string tag);
    tick(2);
    for (int i = 0; i < 7; i++) chk($sformatf("%s reg%0d", tag, i), regs[8*i +: 8], m_view(i));
  endtask

  initial begin
    bit a;
    logic [7:0] v;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 7; i++) model[i] = m_init(i);
    tick(5);
    rst_n = 1'b1;
    tick(5);

    chk("R1 line released after reset", sda_w, 1);
    check_image("R5 R9 reset image");
    read_seq(8);

    // R2: foreign addresses followed by clocked data
    do_start();
    send_byte(8'hA0, a); chk("R2 foreign address nack", a, 0);
    send_byte(8'h00, a); chk("R2 byte after foreign address nack", a, 0);
    send_byte(8'h00, a); chk("R2 second byte ignored", a, 0);
    do_stop();
    do_start();
    send_byte(8'h52, a); chk("R2 wrong top bit nack", a, 0);
    for (int k = 0; k < 4; k++) send_byte(8'h00, a);
    do_stop();
    do_start();
    send_byte(8'hD4, a); chk("R2 neighbour address nack", a, 0);
    do_stop();
    check_image("R2 unchanged after foreign address");

    // R6 R7: all ones then all zeros across nine data bytes
    write_seq(9, 8'hFF, 1'b1);
    check_image("R6 after all ones");
    read_seq(9);
    write_seq(9, 8'h00, 1'b1);
    check_image("R6 after all zeros");
    read_seq(7);

    // R6: strap input shown in reg4 upper nibble
    strap = 4'hA;
    tick(4);
    chk("R6 strap in image", regs[39:32], {4'hA, model[4][3:0]});
    read_seq(5);

    // R8: repeated start in the middle of a write
    do_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
    send_byte(8'h11, a); model_write(0, 8'h11);
    send_byte(8'h02, a); model_write(1, 8'h02);
    do_start();
    send_byte(8'hD2, a); chk("R8 address after restart ack", a, 1);
    send_byte(8'hAA, a); send_byte(8'h55, a);
    send_byte(8'h28, a); model_write(0, 8'h28);
    do_stop();
    check_image("R8 restart write");

    // R8: repeated start in the middle of a read
    do_start();
    send_byte(8'hD3, a);
    get_byte(1'b1, v); get_byte(1'b1, v);
    get_byte(1'b0, v); chk("R8 third byte before restart", v, m_view(2));
    do_start();
    send_byte(8'hD3, a); chk("R8 read address after restart", a, 1);
    get_byte(1'b0, v); chk("R8 read restarts at reg0", v, m_view(0));
    // R4: after the nack the line stays released
    get_byte(1'b0, v); chk("R4 released after nack", v, 8'hFF);
    do_stop();

    // random mix
    for (int it = 0; it < 20; it++) begin
      if (it % 5 == 4) strap = 4'($urandom);
      write_seq($urandom_range(0, 10), 8'h00, 1'b0);
      check_image("R9 random image");
      read_seq($urandom_range(1, 9));
    end

    chk("R1 slave never changes SDA while SCL high", oe_glitch, 0);
    chk("R1 line released at end", sda_w, 1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule